// File: doc/BRIEF.md
# Restartable Post-Increment Move Unit

This unit is the execute-stage register updater for a memory-to-memory move whose two pointer registers both post-increment. It holds a small register file of address/data pointers and a four-bit condition code register. Once an instruction is accepted, the unit makes two memory accesses. The first reads the word at the source pointer and advances that pointer. The second writes the word to the destination pointer, advances that pointer and updates the condition codes.

Either access can end in an error acknowledge. The second access can fail after the source pointer has already moved, so the unit saves the source pointer's starting value in a shadow register. If the write faults, that saved value goes back into the register file on the same clock edge that raises the fault pulse. After any fault, every visible register holds the value it had before the instruction began. The pulse carries the PC of the instruction, and no progress state survives it. The exception logic outside the unit can therefore re-issue the whole instruction from its first cycle.

A plain write port preloads registers while the unit is idle. A combinational read port exposes any register.

Top module: `mm_move_unit`

## Requirements
- R1: After reset, every register and the condition codes are zero, `start_ready` is 1, and `fault_valid` and `mem_req` are 0.
- R2: The first access after `start_valid` is accepted is a read (`mem_we`=0) at the source register's value. When it is acknowledged, the source register increases by STEP (4).
- R3: The second access is a write (`mem_we`=1) of the word just read, at the destination register's current value. When it is acknowledged, the destination register increases by STEP and `start_ready` returns to 1.
- R4: The condition codes are `ccr[3]`=N (bit 31 of the moved word), `ccr[2]`=Z (moved word equal to zero), `ccr[1]`=V=0 and `ccr[0]`=C=0. They change only when the write completes without error.
- R5: If the write gets `mem_err`, both pointers and the condition codes hold their pre-instruction values, and a fault is raised.
- R6: If the read gets `mem_err`, no write is issued, nothing in the register file or condition codes changes, and a fault is raised.
- R7: `fault_valid` is a one-cycle pulse with `fault_pc` equal to the PC given at start. In the pulse cycle the source register already reads back its restored value.
- R8: From a fault until `fault_ack`, `start_ready` stays 0 and `start_valid` is ignored: no access is issued.
- R9: When source and destination indices are equal, a completed move leaves that register 8 above its start value, and a faulted move leaves it unchanged.
- R10: An access is held, with the same address and direction, until `mem_ack` or `mem_err` arrives, so any number of wait cycles is tolerated.
- R11: `wr_en` loads `wr_data` into register `wr_idx` only while `start_ready` is 1. While an instruction is in flight it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to begin a move |
| start_ready | output | 1 | Unit idle and able to accept a move |
| start_src | input | IW | Source pointer register index |
| start_dst | input | IW | Destination pointer register index |
| start_pc | input | PCW | PC of the move instruction |
| wr_en | input | 1 | Register preload strobe |
| wr_idx | input | IW | Preload register index |
| wr_data | input | DW | Preload value |
| rd_idx | input | IW | Read port register index |
| rd_data | output | DW | Register value at `rd_idx` |
| ccr | output | 4 | Condition codes {N,Z,V,C} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | DW | Access address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access completed |
| mem_err | input | 1 | Access terminated with error |
| fault_valid | output | 1 | One-cycle fault pulse |
| fault_pc | output | PCW | PC to restart from |
| fault_ack | input | 1 | Fault accepted; unit may resume |

## Verification
The bench builds the unit with its defaults: eight 32-bit registers, a 32-bit PC and a step of 4. Three-bit indices make random source/destination collisions frequent enough to reach R9 often. Full 32-bit data lets random words and directed zero and negative words drive both N and Z. Random wait counts of zero to two cycles and per-instruction error injection on either access cover every fault position, including a fault that follows an immediate acknowledge.

// File: rtl/mm_move_unit.sv
module mm_move_unit #(
  parameter int NREGS = 8,
  parameter int DW    = 32,
  parameter int PCW   = 32,
  parameter int STEP  = 4,
  localparam int IW   = (NREGS > 1) ? $clog2(NREGS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_valid,
  output logic           start_ready,
  input  logic [IW-1:0]  start_src,
  input  logic [IW-1:0]  start_dst,
  input  logic [PCW-1:0] start_pc,
  input  logic           wr_en,
  input  logic [IW-1:0]  wr_idx,
  input  logic [DW-1:0]  wr_data,
  input  logic [IW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic [3:0]     ccr,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_ack,
  input  logic           mem_err,
  output logic           fault_valid,
  output logic [PCW-1:0] fault_pc,
  input  logic           fault_ack
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR, S_FLT} state_t;

  state_t         state;
  logic [DW-1:0]  rf [NREGS];
  logic [DW-1:0]  shadow;
  logic [DW-1:0]  data_q;
  logic [IW-1:0]  src_q, dst_q;
  logic [PCW-1:0] pc_q;
  logic           commit;

  assign start_ready = (state == S_IDLE);
  assign mem_req     = (state == S_RD) || (state == S_WR);
  assign mem_we      = (state == S_WR);
  assign mem_addr    = (state == S_WR) ? rf[dst_q] : rf[src_q];
  assign mem_wdata   = data_q;
  assign rd_data     = rf[rd_idx];
  assign fault_pc    = pc_q;
  assign commit      = (state == S_WR) && mem_ack && !mem_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      for (int i = 0; i < NREGS; i++) rf[i] <= '0;
      shadow      <= '0;
      data_q      <= '0;
      src_q       <= '0;
      dst_q       <= '0;
      pc_q        <= '0;
      ccr         <= '0;
      fault_valid <= 1'b0;
    end else begin
      fault_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (wr_en) rf[wr_idx] <= wr_data;
          if (start_valid) begin
            src_q  <= start_src;
            dst_q  <= start_dst;
            pc_q   <= start_pc;
            shadow <= rf[start_src];
            state  <= S_RD;
          end
        end
        S_RD: begin
          if (mem_err) begin
            fault_valid <= 1'b1;
            state       <= S_FLT;
          end else if (mem_ack) begin
            data_q     <= mem_rdata;
            rf[src_q]  <= rf[src_q] + DW'(STEP);
            state      <= S_WR;
          end
        end
        S_WR: begin
          if (mem_err) begin
            rf[src_q]   <= shadow;
            fault_valid <= 1'b1;
            state       <= S_FLT;
          end else if (mem_ack) begin
            rf[dst_q] <= rf[dst_q] + DW'(STEP);
            ccr       <= {data_q[DW-1], data_q == '0, 2'b00};
            state     <= S_IDLE;
          end
        end
        default: begin
          if (fault_ack) state <= S_IDLE;
        end
      endcase
    end
  end

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid);

  p_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FLT && !fault_ack) |=> !start_ready && !mem_req);

  p_ccr_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ccr) |-> $past(commit));

  p_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD && mem_err) |=> !mem_req);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !mem_err) |=> mem_req && $stable(mem_we) && $stable(mem_addr));

  p_restore_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR && mem_err) |=> fault_valid && rf[src_q] == $past(shadow));

endmodule

// File: tb/mm_move_unit_tb.sv
`timescale 1ns/100ps
module mm_move_unit_tb;
  localparam int NREGS = 8, DW = 32, PCW = 32, IW = 3;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic start_valid = 0, wr_en = 0, fault_ack = 0;
  logic [IW-1:0] start_src = 0, start_dst = 0, wr_idx = 0, rd_idx = 0;
  logic [PCW-1:0] start_pc = 0;
  logic [DW-1:0] wr_data = 0, mem_rdata;
  logic mem_ack = 0, mem_err = 0;
  logic start_ready, mem_req, mem_we, fault_valid;
  logic [DW-1:0] rd_data, mem_addr, mem_wdata;
  logic [3:0] ccr;
  logic [PCW-1:0] fault_pc;

  mm_move_unit #(.NREGS(NREGS), .DW(DW), .PCW(PCW), .STEP(4)) u_dut (
    .clk, .rst_n, .start_valid, .start_ready, .start_src, .start_dst, .start_pc,
    .wr_en, .wr_idx, .wr_data, .rd_idx, .rd_data, .ccr, .mem_req, .mem_we,
    .mem_addr, .mem_wdata, .mem_rdata, .mem_ack, .mem_err, .fault_valid,
    .fault_pc, .fault_ack);

  int checks = 0, fails = 0;
  logic [DW-1:0] mem [64];
  logic [DW-1:0] m_regs [NREGS];
  logic [3:0] m_ccr = 0;
  int inj_mode = 0, nwrites = 0, lat = 0;
  bit fresh = 1;

  assign mem_rdata = mem[mem_addr[7:2]];

  always @(negedge clk) begin
    mem_ack = 0; mem_err = 0;
    if (rst_n && mem_req) begin
      if (fresh) begin lat = $urandom_range(0, 2); fresh = 0; end
      if (lat == 0) begin
        fresh = 1;
        if ((!mem_we && inj_mode == 1) || (mem_we && inj_mode == 2)) mem_err = 1;
        else begin
          mem_ack = 1;
          if (mem_we) begin mem[mem_addr[7:2]] = mem_wdata; nwrites++; end
        end
      end else lat--;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cc_of(input logic [DW-1:0] d);
    return {d[DW-1], d == 0, 2'b00};
  endfunction

  task automatic compare_all(input string req);
    for (int i = 0; i < NREGS; i++) begin
      rd_idx = IW'(i); #0.1;
      chk(rd_data === m_regs[i], req, rd_data, m_regs[i]);
    end
    chk(ccr === m_ccr, req, ccr, m_ccr);
  endtask

  task automatic load_reg(input int idx, input logic [DW-1:0] v);
    @(negedge clk); wr_en = 1; wr_idx = IW'(idx); wr_data = v;
    @(negedge clk); wr_en = 0;
    m_regs[idx] = v;
  endtask

  task automatic run_move(input int src, input int dst, input logic [PCW-1:0] pc,
                          input int inj, input bit poke);
    logic [DW-1:0] s0, data, dptr;
    int w0;
    s0 = m_regs[src];
    data = mem[s0[7:2]];
    inj_mode = inj; w0 = nwrites;
    rd_idx = IW'(src);
    @(negedge clk);
    start_valid = 1; start_src = IW'(src); start_dst = IW'(dst); start_pc = pc;
    @(negedge clk); start_valid = 0;
    chk(mem_req && !mem_we && mem_addr === s0, "R2", mem_addr, s0);
    if (poke) begin
      wr_en = 1; wr_idx = IW'((src + 1) % NREGS); wr_data = 32'hDEAD_BEE0;
      @(negedge clk); wr_en = 0;
    end
    while (!fault_valid && !start_ready) @(negedge clk);
    if (fault_valid) begin
      chk(inj != 0, "R5", inj, 0);
      chk(fault_pc === pc, "R7", fault_pc, pc);
      chk(rd_data === s0, "R7", rd_data, s0);
      if (inj == 1) chk(nwrites == w0, "R6", nwrites - w0, 0);
      @(negedge clk);
      chk(!fault_valid, "R7", fault_valid, 0);
      start_valid = 1;
      @(negedge clk); start_valid = 0;
      chk(!start_ready && !mem_req, "R8", {start_ready, mem_req}, 0);
      fault_ack = 1;
      @(negedge clk); fault_ack = 0;
      chk(start_ready, "R8", start_ready, 1);
      compare_all(src == dst ? "R9" : (inj == 1 ? "R6" : "R5"));
    end else begin
      chk(inj == 0, "R3", inj, 0);
      m_regs[src] = m_regs[src] + 4;
      dptr = m_regs[dst];
      m_regs[dst] = m_regs[dst] + 4;
      m_ccr = cc_of(data);
      chk(mem[dptr[7:2]] === data, "R3", mem[dptr[7:2]], data);
      compare_all(src == dst ? "R9" : (poke ? "R11" : "R4"));
    end
    inj_mode = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1357_9BDF));
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    for (int i = 0; i < NREGS; i++) m_regs[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(start_ready && !fault_valid && !mem_req, "R1", {start_ready, fault_valid, mem_req}, 4);
    compare_all("R1");
    for (int i = 0; i < NREGS; i++) load_reg(i, 32'(i * 16));
    compare_all("R11");

    mem[0] = 0;
    run_move(0, 1, 32'h100, 0, 0);
    chk(ccr === 4'b0100, "R4", ccr, 4'b0100);
    mem[m_regs[2][7:2]] = 32'h8000_0001;
    run_move(2, 3, 32'h104, 0, 0);
    chk(ccr === 4'b1000, "R4", ccr, 4'b1000);
    run_move(4, 5, 32'h108, 2, 0);
    run_move(5, 6, 32'h10C, 1, 0);
    run_move(3, 3, 32'h110, 0, 0);
    run_move(3, 3, 32'h114, 2, 0);
    run_move(6, 7, 32'h118, 0, 1);

    for (int n = 0; n < 300; n++) begin
      int s, d, r, inj;
      s = $urandom_range(0, NREGS - 1);
      d = ($urandom_range(0, 4) == 0) ? s : $urandom_range(0, NREGS - 1);
      r = $urandom_range(0, 99);
      inj = (r < 70) ? 0 : (r < 85 ? 1 : 2);
      if ($urandom_range(0, 9) == 0) load_reg(s, 32'($urandom_range(0, 63) * 4));
      run_move(s, d, 32'($urandom), inj, $urandom_range(0, 9) == 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule